// File: doc/BRIEF.md
# Frame-Synchronised 14-bit Serial Sample Port

This block is the digital sample port of a voice codec. All of its logic runs on a fast system clock. It oversamples an externally supplied bit clock, a frame sync pulse and a serial data input. The sync pulse rises in phase with a bit-clock rising edge and marks the start of a frame.

On the receive side the port captures the first 14 bits after the frame start, most significant bit first, on bit-clock falling edges. It then presents them as one parallel two's complement word together with a single-cycle strobe. On the transmit side it latches a parallel word when the frame starts. It plays that word out for exactly 14 bit slots on an output that can only pull low or release, and it relies on an external pull-up for the high level.

The port also watches both external clocks. If the bit clock or the sync pulse stops toggling for a programmable number of system-clock cycles, both directions fall silent and a power-saving flag rises. An active-low power-down input has the same effect at once. Traffic resumes only after two complete frames of healthy clocks have been seen.

Top module: `pcm_port`

## Requirements
- R1: Receive bits are sampled on bit-clock falling edges. The first falling edge after a sync rising edge carries bit 13, the sign bit, and later edges carry bits in descending order, so `rx_sample` equals the 14-bit two's complement word sent.
- R2: On the 14th falling edge of a frame, `rx_sample` is updated and `rx_strobe` goes high for exactly one system-clock cycle, 3 cycles after the edge at the pins.
- R3: Bits that arrive after the 14th, and before the next sync rising edge, are ignored: they give no further strobe and `rx_sample` keeps its value.
- R4: `tx_sample` is captured at the sync rising edge, so a change to it during the frame does not alter the bits sent.
- R5: Transmit bit 13 is presented from the sync rising edge. After the i-th following bit-clock rising edge, bit 13-i is presented, each change visible 3 system-clock cycles after the edge at the pins.
- R6: Open-drain coding applies: `sdo_pull_low` is 1 for a 0 bit and 0 for a 1 bit. Outside the 14 transmit slots `tx_active` is 0 and `sdo_pull_low` is 0 (released).
- R7: If the bit clock shows no edge for `IDLE_LIMIT` system-clock cycles, `saving` goes to 1.
- R8: If the sync input shows no edge for `IDLE_LIMIT` system-clock cycles, `saving` goes to 1 even while the bit clock runs.
- R9: While `saving` is 1, no strobe is produced and the output stays released. `saving` clears at the third sync rising edge seen with healthy clocks, which closes two complete frames, and the frame opened by that edge is handled normally.
- R10: When `pdn_n` is 0, `saving` is 1 from the next cycle on, the output is released and no strobe is produced. After `pdn_n` returns to 1, the resume rule of R9 applies.
- R11: After reset, `saving` is 1, `rx_strobe` is 0, `rx_sample` is 0, and the output is released with `tx_active` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn_n | input | 1 | Active-low power-down, synchronous to clk |
| bit_clk | input | 1 | External serial bit clock |
| frame_sync | input | 1 | Frame sync pulse, rising in phase with bit_clk |
| ser_in | input | 1 | Serial receive data |
| tx_sample | input | SAMPLE_W | Parallel transmit word, two's complement |
| rx_sample | output | SAMPLE_W | Last received word, two's complement |
| rx_strobe | output | 1 | One-cycle pulse when rx_sample is updated |
| sdo_pull_low | output | 1 | 1 pulls the serial output low, 0 releases it |
| tx_active | output | 1 | High during the 14 transmit slots |
| saving | output | 1 | Power-saving / power-down indication |

## Verification
Each pin change travels through a two-stage synchronizer and then one register. The bench therefore drives inputs on a falling system-clock edge and samples every transmit bit and the receive strobe three cycles later, on a falling edge. It also samples once more one cycle later, to prove that the strobe has already dropped. Clock-stall entry is checked only after the idle limit plus a margin has passed. Power-down is checked two cycles after `pdn_n` falls, which is one cycle beyond the required single cycle. A negedge monitor counts strobes per frame, so extra or missing words are caught regardless of when they occur.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
   // index of each oversampled pin inside the synchronizer vector
   typedef enum int unsigned {
      PIN_BCLK = 0,
      PIN_SYNC = 1,
      PIN_DATA = 2
   } pin_e;

   localparam int unsigned NUM_PINS   = 3;
   localparam int unsigned NUM_CLKPIN = 2;   // pins watched for activity
endpackage

// File: rtl/pcm_port_sync.sv
module pcm_port_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] chain [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/pcm_port_idle.sv
module pcm_port_idle #(
   parameter int unsigned IDLE_LIMIT    = 40000,
   parameter int unsigned RESUME_FRAMES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pdn_n,
   input  logic [1:0] activity,     // any edge per watched clock pin
   input  logic       sync_rise,
   output logic       saving,
   output logic       halt,
   output logic       frame_start
);
   localparam int unsigned CW = $clog2(IDLE_LIMIT + 1);
   localparam int unsigned RW = $clog2(RESUME_FRAMES + 1);

   logic [1:0]    stall_v;
   logic          stalled;
   logic          save_q;
   logic [RW-1:0] seen_q;
   logic          resume_now;

   for (genvar j = 0; j < 2; j++) begin : g_watch
      logic [CW-1:0] idle_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         idle_q <= '0;
         else if (activity[j])               idle_q <= '0;
         else if (idle_q != CW'(IDLE_LIMIT)) idle_q <= idle_q + 1'b1;
      end
      // an edge arriving this cycle already cancels the stall
      assign stall_v[j] = (idle_q == CW'(IDLE_LIMIT)) && !activity[j];
   end

   assign stalled    = |stall_v;
   assign resume_now = save_q && pdn_n && !stalled && sync_rise &&
                       (seen_q == RW'(RESUME_FRAMES));
   assign halt        = !pdn_n || stalled || (save_q && !resume_now);
   assign frame_start = sync_rise && !halt;
   assign saving      = save_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         save_q <= 1'b1;
         seen_q <= '0;
      end else if (!pdn_n || stalled) begin
         save_q <= 1'b1;
         seen_q <= '0;
      end else if (resume_now) begin
         save_q <= 1'b0;
         seen_q <= '0;
      end else if (save_q && sync_rise) begin
         seen_q <= seen_q + 1'b1;
      end
   end
endmodule

// File: rtl/pcm_port_rx.sv
module pcm_port_rx #(
   parameter int unsigned W = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         halt,
   input  logic         frame_start,
   input  logic         bit_fall,
   input  logic         bit_in,
   output logic [W-1:0] word,
   output logic         valid
);
   localparam int unsigned CW = $clog2(W + 1);

   logic [W-2:0]  sh_q;
   logic [CW-1:0] cnt_q;    // W means idle until next frame

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= CW'(W);
         word  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (halt) begin
            cnt_q <= CW'(W);
         end else if (frame_start) begin
            cnt_q <= '0;
         end else if (bit_fall && cnt_q != CW'(W)) begin
            sh_q  <= {sh_q[W-3:0], bit_in};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(W - 1)) begin
               word  <= {sh_q, bit_in};
               valid <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pcm_port_tx.sv
module pcm_port_tx #(
   parameter int unsigned W = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         halt,
   input  logic         frame_start,
   input  logic         bit_rise,
   input  logic [W-1:0] word_in,
   output logic         active,
   output logic         pull_low
);
   localparam int unsigned CW = $clog2(W);

   logic [W-1:0]  sh_q;
   logic [CW-1:0] cnt_q;
   logic          act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
         act_q <= 1'b0;
      end else if (halt) begin
         act_q <= 1'b0;
      end else if (frame_start) begin
         sh_q  <= word_in;
         cnt_q <= '0;
         act_q <= 1'b1;
      end else if (bit_rise && act_q) begin
         if (cnt_q == CW'(W - 1)) begin
            act_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
            sh_q  <= {sh_q[W-2:0], 1'b0};
         end
      end
   end

   assign active   = act_q;
   assign pull_low = act_q && !sh_q[W-1];
endmodule

// File: rtl/pcm_port.sv
module pcm_port #(
   parameter int unsigned SAMPLE_W      = 14,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned IDLE_LIMIT    = 40000,
   parameter int unsigned RESUME_FRAMES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pdn_n,
   input  logic                bit_clk,
   input  logic                frame_sync,
   input  logic                ser_in,
   input  logic [SAMPLE_W-1:0] tx_sample,
   output logic [SAMPLE_W-1:0] rx_sample,
   output logic                rx_strobe,
   output logic                sdo_pull_low,
   output logic                tx_active,
   output logic                saving
);
   import pcm_port_pkg::*;

   if (SAMPLE_W < 4 || SAMPLE_W > 32) begin : g_bad_width
      $error("pcm_port: SAMPLE_W out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("pcm_port: SYNC_STAGES must be at least 2");
   end
   if (IDLE_LIMIT < 16) begin : g_bad_limit
      $error("pcm_port: IDLE_LIMIT too small");
   end
   if (RESUME_FRAMES < 1) begin : g_bad_resume
      $error("pcm_port: RESUME_FRAMES must be at least 1");
   end

   logic [NUM_PINS-1:0]   raw_pins;
   logic [NUM_PINS-1:0]   lvl;
   logic [NUM_CLKPIN-1:0] last_q;
   logic [NUM_CLKPIN-1:0] rise_ev;
   logic [NUM_CLKPIN-1:0] any_ev;
   logic                  bclk_fall;
   logic                  halt;
   logic                  frame_start;

   assign raw_pins[PIN_BCLK] = bit_clk;
   assign raw_pins[PIN_SYNC] = frame_sync;
   assign raw_pins[PIN_DATA] = ser_in;

   pcm_port_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_pins),
      .dout (lvl)
   );

   for (genvar p = 0; p < NUM_CLKPIN; p++) begin : g_edge
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) last_q[p] <= 1'b0;
         else        last_q[p] <= lvl[p];
      end
      assign rise_ev[p] = lvl[p] && !last_q[p];
      assign any_ev[p]  = lvl[p] ^ last_q[p];
   end

   assign bclk_fall = any_ev[PIN_BCLK] && !rise_ev[PIN_BCLK];

   pcm_port_idle #(.IDLE_LIMIT(IDLE_LIMIT), .RESUME_FRAMES(RESUME_FRAMES)) u_idle (
      .clk        (clk),
      .rst_n      (rst_n),
      .pdn_n      (pdn_n),
      .activity   (any_ev),
      .sync_rise  (rise_ev[PIN_SYNC]),
      .saving     (saving),
      .halt       (halt),
      .frame_start(frame_start)
   );

   pcm_port_rx #(.W(SAMPLE_W)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .halt       (halt),
      .frame_start(frame_start),
      .bit_fall   (bclk_fall),
      .bit_in     (lvl[PIN_DATA]),
      .word       (rx_sample),
      .valid      (rx_strobe)
   );

   pcm_port_tx #(.W(SAMPLE_W)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .halt       (halt),
      .frame_start(frame_start),
      .bit_rise   (rise_ev[PIN_BCLK]),
      .word_in    (tx_sample),
      .active     (tx_active),
      .pull_low   (sdo_pull_low)
   );
endmodule

// File: rtl/pcm_port_chk.sv
module pcm_port_chk (
   input logic clk,
   input logic rst_n,
   input logic pdn_n,
   input logic rx_strobe,
   input logic tx_active,
   input logic sdo_pull_low,
   input logic saving
);
   p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe |=> !rx_strobe);

   p_release_outside_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_active |-> !sdo_pull_low);

   p_quiet_saving_r9: assert property (@(posedge clk) disable iff (!rst_n)
      saving |-> (!tx_active && !rx_strobe));

   p_pdown_enter_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !pdn_n |=> (saving && !tx_active));

   p_pdown_no_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!pdn_n && $past(!pdn_n)) |-> !rx_strobe);
endmodule

bind pcm_port pcm_port_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pdn_n       (pdn_n),
   .rx_strobe   (rx_strobe),
   .tx_active   (tx_active),
   .sdo_pull_low(sdo_pull_low),
   .saving      (saving)
);

// File: tb/sim_pcm_port.sv
`timescale 1ns/1ps
module sim_pcm_port;
   localparam int W     = 14;
   localparam int SLOTS = 18;
   localparam int LIMIT = 300;

   logic         clk = 1'b0;
   logic         rst_n, pdn_n, bit_clk, frame_sync, ser_in;
   logic [W-1:0] tx_sample, rx_sample;
   logic         rx_strobe, sdo_pull_low, tx_active, saving;

   int checks = 0;
   int errors = 0;
   int vcount = 0;

   always #4 clk = ~clk;

   pcm_port #(.SAMPLE_W(W), .SYNC_STAGES(2), .IDLE_LIMIT(LIMIT), .RESUME_FRAMES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .bit_clk(bit_clk),
      .frame_sync(frame_sync), .ser_in(ser_in), .tx_sample(tx_sample),
      .rx_sample(rx_sample), .rx_strobe(rx_strobe), .sdo_pull_low(sdo_pull_low),
      .tx_active(tx_active), .saving(saving)
   );

   always @(negedge clk) if (rst_n && rx_strobe) vcount++;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait3();
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   // one frame of SLOTS bit periods; starts and ends on a negedge
   task automatic run_frame(input logic [W-1:0] rxw, input logic [W-1:0] txw,
                            input bit live, input bit swap_tx);
      int v0 = vcount;
      tx_sample = txw;
      for (int s = 0; s < SLOTS; s++) begin
         bit_clk    = 1'b1;
         frame_sync = (s == 0);
         ser_in     = (s < W) ? rxw[W-1-s] : s[0];   // junk after bit 14 (R3)
         if (swap_tx && s == 5) tx_sample = ~txw;    // R4
         wait3();
         if (live && s < W) begin
            chk("R5 tx_active in slot", tx_active, 1);
            chk("R6/R4 serial bit", sdo_pull_low, !txw[W-1-s]);
         end else begin
            chk("R6/R9 tx_active idle", tx_active, 0);
            chk("R6/R9 released", sdo_pull_low, 0);
         end
         @(negedge clk);
         bit_clk = 1'b0;
         wait3();
         if (live && s == W-1) begin
            chk("R2 strobe high", rx_strobe, 1);
            chk("R1 received word", rx_sample, rxw);
         end
         @(negedge clk);
         if (live && s == W-1) chk("R2 strobe one cycle", rx_strobe, 0);
      end
      chk("R3/R9 strobes per frame", vcount - v0, live ? 1 : 0);
      if (live) chk("R3 word held after extra bits", rx_sample, rxw);
   endtask

   task automatic free_slots(input int n);   // bit clock runs, sync held low
      frame_sync = 1'b0;
      for (int s = 0; s < n; s++) begin
         bit_clk = 1'b1; repeat (4) @(negedge clk);
         bit_clk = 1'b0; repeat (4) @(negedge clk);
      end
   endtask

   task automatic resume(input logic [W-1:0] a, input logic [W-1:0] b);
      run_frame(a, b, 0, 0);
      chk("R9 saving after one frame", saving, 1);
      run_frame(b, a, 0, 0);
      chk("R9 saving after two frames", saving, 1);
      run_frame(a, b, 1, 0);
      chk("R9 saving cleared", saving, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; pdn_n = 1'b1; bit_clk = 1'b0; frame_sync = 1'b0;
      ser_in = 1'b0; tx_sample = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 saving", saving, 1);
      chk("R11 rx_strobe", rx_strobe, 0);
      chk("R11 rx_sample", rx_sample, 0);
      chk("R11 tx_active", tx_active, 0);
      chk("R11 released", sdo_pull_low, 0);

      resume(14'h1234, 14'h2F0C);

      // fixed corner patterns
      run_frame(14'h0000, 14'h3FFF, 1, 0);
      run_frame(14'h3FFF, 14'h0000, 1, 1);
      run_frame(14'h2000, 14'h1FFF, 1, 0);
      run_frame(14'h1FFF, 14'h2000, 1, 1);
      run_frame(14'h2AAA, 14'h1555, 1, 0);
      run_frame(14'h1555, 14'h2AAA, 1, 0);
      // walking ones / zeros sweep
      for (int k = 0; k < W; k++) begin
         logic [W-1:0] one = W'(1) << k;
         run_frame(one, ~one, 1, k[0]);
      end

      // R7: bit clock stops
      bit_clk = 1'b0; frame_sync = 1'b0;
      repeat (LIMIT + 50) @(negedge clk);
      chk("R7 saving on stopped bit clock", saving, 1);
      chk("R7 output released", sdo_pull_low, 0);
      resume(14'h0F0F, 14'h30C3);

      // R8: sync stops while bit clock runs
      free_slots(40);
      chk("R8 saving on stopped sync", saving, 1);
      chk("R8 tx idle", tx_active, 0);
      resume(14'h2468, 14'h1357);

      // R10: power-down
      pdn_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R10 saving in power-down", saving, 1);
      run_frame(14'h0ABC, 14'h1DEF, 0, 0);
      chk("R10 saving still set", saving, 1);
      pdn_n = 1'b1;
      resume(14'h3210, 14'h0123);
      run_frame(14'h2222, 14'h1111, 1, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule